// File: doc/BRIEF.md
# Warm Reset Sequencer

This block turns any one of seven warm-reset requests into a timed reset sequence on a shared, open-drain system reset line. Once a request is accepted, the block pulls the line low for a fixed number of clock cycles. It then lets go of the line and waits through a settle window, so that an external pull-up resistor can raise it. At the end of that window it reads the line again. If something outside still holds the line low, the whole pull-then-release sequence runs again.

In satellite mode, a PCI reset input also takes part. It passes through a synchronizer and a stability filter. While the filtered level is asserted at the end of the settle window, the block stays in reset. If the line is pulled low during that wait, the sequence starts over.

When the sequence ends, the block sends the processor a one-cycle soft-reset pulse. It keeps the boot chip-select gated for a guard interval after that pulse. Transactions stay inhibited from the moment a request is taken until the boot chip-select is allowed again. A cause register records which sources started the most recent sequence, and software clears its bits by writing ones.

Top module: `wrst_seq`

## Requirements
- R1: In idle, any of seven qualified requests starts a sequence: `pin_oe` goes high in the cycle after the request is seen. The cause bit positions are 0 line low, 1 software write, 2 bus timer, 3 watchdog, 4 management write, 5 PCI reset, 6 debug.
- R2: A software write (`sw_wr_en` high) is a request only when `sw_wr_data` equals 0x8000_0001. Any other value, and any value presented while `sw_wr_en` is low, starts nothing.
- R3: A watchdog time-out is a request only while `wdog_rst_en` is high.
- R4: `pci_rst_n` counts as a request, and is checked at the end of the settle window, only while `sat_mode` is high. It passes through a 2-flop synchronizer and then a filter that changes its output only after the input has been stable for 8 consecutive cycles.
- R5: Each drive phase holds `pin_oe` high for exactly 4096 consecutive cycles.
- R6: After each drive phase, `pin_oe` stays low for a 4096-cycle settle window, after which the line is sampled. If the line is low, a new drive phase starts in the next cycle.
- R7: In satellite mode, if the line is high but the filtered PCI reset is asserted at the end of the window, `blk_rst` stays high until that reset negates. If the line goes low during this wait, a drive phase starts in the next cycle.
- R8: When the sequence ends, `cpu_soft_rst` is high for exactly one cycle, and `blk_rst` is low from that cycle onward.
- R9: `boot_cs_en` is low from the first drive cycle. It returns high exactly 16 cycles after the first cycle of the soft-reset pulse.
- R10: `xact_inhibit` is high whenever `blk_rst` is high. It stays high until `boot_cs_en` returns high.
- R11: On the cycle a sequence starts, `cause` is loaded with every request seen in that cycle. Requests that arrive during a running sequence have no effect on it. Writing 1 to a bit of `cause_clr` clears that bit, and writing 0 leaves it unchanged.
- R12: After reset, `pin_oe`, `blk_rst`, `xact_inhibit`, `cpu_soft_rst` and `cause` are all 0, and `boot_cs_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low |
| pin_in | input | 1 | Sampled level of the shared reset line (0 = asserted) |
| sw_wr_en | input | 1 | Software write strobe for the reset command |
| sw_wr_data | input | 32 | Software write data |
| bus_tmo | input | 1 | Bus transaction timer time-out pulse |
| wdog_tmo | input | 1 | Watchdog time-out pulse |
| wdog_rst_en | input | 1 | Allows the watchdog to request a warm reset |
| mgmt_wr_rst | input | 1 | Warm-reset bit write from the PCI management register |
| pci_rst_n | input | 1 | PCI reset, asynchronous, active low |
| dbg_prst | input | 1 | Processor-reset request from the debug logic |
| sat_mode | input | 1 | Satellite-mode strap |
| cause_clr | input | 7 | Write-1-to-clear mask for the cause register |
| pin_oe | output | 1 | Drive the reset line low when 1 |
| blk_rst | output | 1 | Internal block reset |
| xact_inhibit | output | 1 | Memory and peripheral transaction inhibit |
| cpu_soft_rst | output | 1 | One-cycle processor soft-reset pulse |
| boot_cs_en | output | 1 | Boot chip-select allowed |
| cause | output | 7 | Sources that started the most recent sequence |

## Verification
The hardest state to reach is the wait on PCI reset, and especially a restart from inside it. To get there, the line must be released and read high at the end of the window while the filtered PCI reset is still asserted. The stimulus holds `pci_rst_n` low across a whole sequence in satellite mode. It releases the reset 100 cycles after the window ends, which shows that the block is really waiting. A second run pulls the line low 50 cycles into that wait. The bench then checks that a new drive phase starts and that the later PCI release still completes the sequence.

// File: rtl/wrst_pkg.sv
package wrst_pkg;

  localparam int NSRC     = 7;
  localparam int SRC_PIN  = 0;
  localparam int SRC_SW   = 1;
  localparam int SRC_BUS  = 2;
  localparam int SRC_WDOG = 3;
  localparam int SRC_MGMT = 4;
  localparam int SRC_PCI  = 5;
  localparam int SRC_DBG  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_SETTLE,
    ST_PCIWAIT,
    ST_GAP
  } wrst_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // True on the last cycle of a phase that lasts len cycles, counting from 0.
  function automatic logic phase_last(int unsigned cnt, int unsigned len);
    return cnt == (len - 1);
  endfunction

  function automatic int unsigned cnt_bits(int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/wrst_pci_filt.sv
module wrst_pci_filt #(
  parameter int STABLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic filt_n
);
  import wrst_pkg::*;

  localparam int CW = cnt_bits(STABLE);

  logic          sync1_q, sync2_q;
  logic          filt_q;
  logic [CW-1:0] run_q;
  logic          differs;
  logic          run_full;

  assign differs  = (sync2_q != filt_q);
  assign run_full = phase_last(32'(run_q), STABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      filt_q  <= 1'b1;
      run_q   <= '0;
    end else begin
      sync1_q <= raw_n;
      sync2_q <= sync1_q;
      if (!differs) begin
        run_q <= '0;
      end else if (run_full) begin
        filt_q <= sync2_q;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign filt_n = filt_q;

  // Filtered output only ever takes the value the synchronizer held just before.
  assert_filt_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(sync2_q)));

endmodule

// File: rtl/wrst_req_qual.sv
module wrst_req_qual #(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] RST_KEY = DATA_W'(32'h8000_0001)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pin_in,
  input  logic                      sw_wr_en,
  input  logic [DATA_W-1:0]         sw_wr_data,
  input  logic                      bus_tmo,
  input  logic                      wdog_tmo,
  input  logic                      wdog_rst_en,
  input  logic                      mgmt_wr_rst,
  input  logic                      pci_filt_n,
  input  logic                      sat_mode,
  input  logic                      dbg_prst,
  output logic [wrst_pkg::NSRC-1:0] req_vec
);
  import wrst_pkg::*;

  logic sw_hit;
  logic wdog_hit;
  logic pci_hit;

  assign sw_hit   = sw_wr_en && (sw_wr_data == RST_KEY);
  assign wdog_hit = wdog_tmo && wdog_rst_en;
  assign pci_hit  = sat_mode && !pci_filt_n;

  always_comb begin
    req_vec           = '0;
    req_vec[SRC_PIN]  = !pin_in;
    req_vec[SRC_SW]   = sw_hit;
    req_vec[SRC_BUS]  = bus_tmo;
    req_vec[SRC_WDOG] = wdog_hit;
    req_vec[SRC_MGMT] = mgmt_wr_rst;
    req_vec[SRC_PCI]  = pci_hit;
    req_vec[SRC_DBG]  = dbg_prst;
  end

  assert_sw_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_data != RST_KEY) |-> !req_vec[SRC_SW]);

  assert_wdog_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wdog_rst_en |-> !req_vec[SRC_WDOG]);

  assert_pci_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_mode |-> !req_vec[SRC_PCI]);

endmodule

// File: rtl/wrst_fsm.sv
module wrst_fsm #(
  parameter int DRIVE_CYC  = 4096,
  parameter int SETTLE_CYC = 4096,
  parameter int GAP_CYC    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic pin_in,
  input  logic pci_hold,
  output logic start,
  output logic pin_oe,
  output logic blk_rst,
  output logic xact_inhibit,
  output logic cpu_soft_rst,
  output logic boot_cs_en
);
  import wrst_pkg::*;

  localparam int CW = cnt_bits(max3(DRIVE_CYC, SETTLE_CYC, GAP_CYC));

  wrst_state_e   st_q, st_nxt;
  logic [CW-1:0] cnt_q;
  logic          cnt_clr;
  logic          soft_q;
  logic          drive_done, settle_done, gap_done;
  logic          sample_ev;
  logic          enter_gap;

  assign drive_done  = phase_last(32'(cnt_q), DRIVE_CYC);
  assign settle_done = phase_last(32'(cnt_q), SETTLE_CYC);
  assign gap_done    = phase_last(32'(cnt_q), GAP_CYC);
  assign sample_ev   = (st_q == ST_SETTLE) && settle_done;

  always_comb begin
    st_nxt  = st_q;
    cnt_clr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (any_req) st_nxt = ST_DRIVE;
      end
      ST_DRIVE: begin
        if (drive_done) begin
          st_nxt  = ST_SETTLE;
          cnt_clr = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (sample_ev) begin
          cnt_clr = 1'b1;
          if (!pin_in)       st_nxt = ST_DRIVE;
          else if (pci_hold) st_nxt = ST_PCIWAIT;
          else               st_nxt = ST_GAP;
        end
      end
      ST_PCIWAIT: begin
        cnt_clr = 1'b1;
        if (!pin_in)        st_nxt = ST_DRIVE;
        else if (!pci_hold) st_nxt = ST_GAP;
      end
      ST_GAP: begin
        if (gap_done) begin
          st_nxt  = ST_IDLE;
          cnt_clr = 1'b1;
        end
      end
      default: begin
        st_nxt  = ST_IDLE;
        cnt_clr = 1'b1;
      end
    endcase
  end

  assign enter_gap = (st_nxt == ST_GAP) && (st_q != ST_GAP);
  assign start     = (st_q == ST_IDLE) && any_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      soft_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      cnt_q  <= cnt_clr ? '0 : cnt_q + 1'b1;
      soft_q <= enter_gap;
    end
  end

  assign pin_oe       = (st_q == ST_DRIVE);
  assign blk_rst      = (st_q == ST_DRIVE) || (st_q == ST_SETTLE) || (st_q == ST_PCIWAIT);
  assign xact_inhibit = (st_q != ST_IDLE);
  assign boot_cs_en   = (st_q == ST_IDLE);
  assign cpu_soft_rst = soft_q;

  // Checker counter: length of the current run of pin_oe.
  int unsigned oe_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_run_q <= 0;
    else        oe_run_q <= pin_oe ? oe_run_q + 1 : 0;
  end

  assert_drive_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_oe) |-> (oe_run_q == DRIVE_CYC));

  assert_soft_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_soft_rst |=> !cpu_soft_rst);

  assert_soft_norst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_soft_rst |-> !blk_rst);

  assert_boot_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_soft_rst |-> !boot_cs_en);

  assert_inhibit_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_rst |-> xact_inhibit);

  assert_pciwait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PCIWAIT) |-> (blk_rst && !pin_oe));

endmodule

// File: rtl/wrst_seq.sv
module wrst_seq #(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] RST_KEY    = DATA_W'(32'h8000_0001),
  parameter int                DRIVE_CYC  = 4096,
  parameter int                SETTLE_CYC = 4096,
  parameter int                GAP_CYC    = 16,
  parameter int                FILT_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              sw_wr_en,
  input  logic [DATA_W-1:0] sw_wr_data,
  input  logic              bus_tmo,
  input  logic              wdog_tmo,
  input  logic              wdog_rst_en,
  input  logic              mgmt_wr_rst,
  input  logic              pci_rst_n,
  input  logic              dbg_prst,
  input  logic              sat_mode,
  input  logic [6:0]        cause_clr,
  output logic              pin_oe,
  output logic              blk_rst,
  output logic              xact_inhibit,
  output logic              cpu_soft_rst,
  output logic              boot_cs_en,
  output logic [6:0]        cause
);
  import wrst_pkg::*;

  logic            pci_filt_n;
  logic [NSRC-1:0] req_vec;
  logic            any_req;
  logic            pci_hold;
  logic            start;
  logic [NSRC-1:0] cause_q;

  wrst_pci_filt #(.STABLE(FILT_CYC)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_n  (pci_rst_n),
    .filt_n (pci_filt_n)
  );

  wrst_req_qual #(.DATA_W(DATA_W), .RST_KEY(RST_KEY)) u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_in      (pin_in),
    .sw_wr_en    (sw_wr_en),
    .sw_wr_data  (sw_wr_data),
    .bus_tmo     (bus_tmo),
    .wdog_tmo    (wdog_tmo),
    .wdog_rst_en (wdog_rst_en),
    .mgmt_wr_rst (mgmt_wr_rst),
    .pci_filt_n  (pci_filt_n),
    .sat_mode    (sat_mode),
    .dbg_prst    (dbg_prst),
    .req_vec     (req_vec)
  );

  assign any_req  = |req_vec;
  assign pci_hold = sat_mode && !pci_filt_n;

  wrst_fsm #(
    .DRIVE_CYC  (DRIVE_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .GAP_CYC    (GAP_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .any_req      (any_req),
    .pin_in       (pin_in),
    .pci_hold     (pci_hold),
    .start        (start),
    .pin_oe       (pin_oe),
    .blk_rst      (blk_rst),
    .xact_inhibit (xact_inhibit),
    .cpu_soft_rst (cpu_soft_rst),
    .boot_cs_en   (boot_cs_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cause_q <= '0;
    else if (start) cause_q <= req_vec;
    else            cause_q <= cause_q & ~cause_clr;
  end

  assign cause = cause_q;

  assert_cause_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (cause_clr == '0)) |=> $stable(cause_q));

  assert_cause_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cause_q == $past(req_vec)));

  assert_start_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pin_oe);

endmodule

// File: tb/wrst_seq_test.sv
module wrst_seq_test;

  localparam int DRIVE  = 4096;
  localparam int SETTLE = 4096;
  localparam int GAP    = 16;
  localparam logic [31:0] KEY = 32'h8000_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_low = 1'b0;
  logic        pin_in;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic        bus_tmo = 1'b0, wdog_tmo = 1'b0, wdog_rst_en = 1'b1;
  logic        mgmt_wr_rst = 1'b0, pci_rst_n = 1'b1, dbg_prst = 1'b0, sat_mode = 1'b0;
  logic [6:0]  cause_clr = '0;
  logic        pin_oe, blk_rst, xact_inhibit, cpu_soft_rst, boot_cs_en;
  logic [6:0]  cause;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  assign pin_in = (pin_oe || ext_low) ? 1'b0 : 1'b1;

  wrst_seq uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sw_wr_en(sw_wr_en),
    .sw_wr_data(sw_wr_data), .bus_tmo(bus_tmo), .wdog_tmo(wdog_tmo),
    .wdog_rst_en(wdog_rst_en), .mgmt_wr_rst(mgmt_wr_rst), .pci_rst_n(pci_rst_n),
    .dbg_prst(dbg_prst), .sat_mode(sat_mode), .cause_clr(cause_clr),
    .pin_oe(pin_oe), .blk_rst(blk_rst), .xact_inhibit(xact_inhibit),
    .cpu_soft_rst(cpu_soft_rst), .boot_cs_en(boot_cs_en), .cause(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cause(input int src);
    return 1 << src;
  endfunction

  function automatic bit sw_qualifies(input bit en, input logic [31:0] data);
    return en && (data == KEY);
  endfunction

  task automatic idle_quiet(input string req, input int cyc, input int exp_c);
    int hits = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pin_oe !== 1'b0 || boot_cs_en !== 1'b1) hits++;
    end
    chk(req, hits, 0);
    chk(req, int'(cause), exp_c);
  endtask

  task automatic fire(input int src);
    case (src)
      0: ext_low = 1'b1;
      1: begin sw_wr_en = 1'b1; sw_wr_data = KEY; end
      2: bus_tmo = 1'b1;
      3: begin wdog_rst_en = 1'b1; wdog_tmo = 1'b1; end
      4: mgmt_wr_rst = 1'b1;
      5: begin sat_mode = 1'b1; pci_rst_n = 1'b0; end
      default: dbg_prst = 1'b1;
    endcase
    @(negedge clk);
    sw_wr_en = 1'b0; bus_tmo = 1'b0; wdog_tmo = 1'b0; mgmt_wr_rst = 1'b0; dbg_prst = 1'b0;
    for (int w = 0; w < 40 && pin_oe !== 1'b1; w++) @(negedge clk);
  endtask

  // Runs one full warm-reset sequence and checks its timing.
  task automatic run_seq(input int src, input int loops, input int pci_rel, input int reassert_at);
    int  loops_left = loops;
    int  re_at = reassert_at;
    bit  re_pending = 1'b0;
    int  n, m, g, soft_cnt;
    fire(src);
    chk("R1 sequence starts", int'(pin_oe), 1);
    chk("R9 boot gated", int'(boot_cs_en), 0);
    forever begin
      ext_low = (loops_left > 0);
      n = 0;
      while (pin_oe === 1'b1 && n < 10000) begin
        if (src != 2 && n == 100) bus_tmo = 1'b1;
        if (n == 101) bus_tmo = 1'b0;
        n++;
        @(negedge clk);
      end
      bus_tmo = 1'b0;
      chk("R5 drive length", n, DRIVE);
      m = 0;
      while (pin_oe !== 1'b1 && cpu_soft_rst !== 1'b1 && m < 20000) begin
        if (pci_rel != 0 && m == pci_rel) begin
          chk("R7 held by pci reset", int'(blk_rst), 1);
          pci_rst_n = 1'b1;
        end
        if (re_at != 0 && m == re_at) begin
          ext_low = 1'b1;
          re_pending = 1'b1;
          re_at = 0;
        end
        m++;
        @(negedge clk);
      end
      if (pin_oe === 1'b1) begin
        if (re_pending) begin
          chk("R7 restart from pci wait", m, reassert_at + 1);
          re_pending = 1'b0;
        end else begin
          chk("R6 repeat after window", m, SETTLE);
          loops_left--;
        end
        continue;
      end
      break;
    end
    if (pci_rel != 0) begin
      chk("R7 release latency", int'(m > pci_rel && m <= pci_rel + 16), 1);
    end else begin
      chk("R6 window length", m, SETTLE);
    end
    chk("R8 soft pulse", int'(cpu_soft_rst), 1);
    chk("R8 block reset off", int'(blk_rst), 0);
    chk("R10 inhibit in gap", int'(xact_inhibit), 1);
    g = 0;
    soft_cnt = 0;
    while (boot_cs_en !== 1'b1 && g < 100) begin
      if (cpu_soft_rst === 1'b1) soft_cnt++;
      g++;
      @(negedge clk);
    end
    chk("R9 boot gap", g, GAP);
    chk("R8 single pulse", soft_cnt, 1);
    chk("R10 inhibit released", int'(xact_inhibit), 0);
    chk("R11 cause", int'(cause), exp_cause(src));
    ext_low = 1'b0;
    pci_rst_n = 1'b1;
  endtask

  task automatic clear_cause();
    cause_clr = 7'h7f;
    @(negedge clk);
    cause_clr = '0;
    chk("R11 cleared", int'(cause), 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 pin_oe", int'(pin_oe), 0);
    chk("R12 blk_rst", int'(blk_rst), 0);
    chk("R12 inhibit", int'(xact_inhibit), 0);
    chk("R12 soft", int'(cpu_soft_rst), 0);
    chk("R12 boot", int'(boot_cs_en), 1);
    chk("R12 cause", int'(cause), 0);

    // R1 software command, then partial clear
    run_seq(1, 0, 0, 0);
    cause_clr = 7'h7d;
    @(negedge clk);
    cause_clr = '0;
    chk("R11 clear other bit", int'(cause), exp_cause(1));
    clear_cause();

    // R2 wrong values ignored
    sw_wr_en = 1'b1; sw_wr_data = 32'h8000_0000;
    chk("R2 model", int'(sw_qualifies(sw_wr_en, sw_wr_data)), 0);
    @(negedge clk);
    sw_wr_data = 32'h0000_0001;
    @(negedge clk);
    sw_wr_en = 1'b0; sw_wr_data = KEY;
    @(negedge clk);
    sw_wr_data = '0;
    idle_quiet("R2 bad write ignored", 20, 0);

    // R3 watchdog gated
    wdog_rst_en = 1'b0; wdog_tmo = 1'b1;
    @(negedge clk);
    wdog_tmo = 1'b0;
    idle_quiet("R3 watchdog ignored", 20, 0);
    run_seq(3, 0, 0, 0);
    clear_cause();

    // R1/R6 line held low for two extra loops
    run_seq(0, 2, 0, 0);
    clear_cause();

    // R4 PCI reset ignored outside satellite mode, also at the window end
    sat_mode = 1'b0; pci_rst_n = 1'b0;
    idle_quiet("R4 pci ignored", 30, 0);
    run_seq(6, 0, 0, 0);
    clear_cause();
    pci_rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R4/R7 satellite mode wait on PCI reset
    run_seq(5, 0, SETTLE + 100, 0);
    clear_cause();
    repeat (20) @(negedge clk);

    // R7 line pulled low during the PCI wait
    run_seq(5, 0, SETTLE + 100, SETTLE + 50);
    clear_cause();
    repeat (20) @(negedge clk);
    sat_mode = 1'b0;

    // Random mix
    for (int k = 0; k < 6; k++) begin
      int src = int'($urandom % 7);
      int lp  = (($urandom % 4) == 0) ? 1 : 0;
      if (src == 5) begin
        run_seq(5, 0, SETTLE + 100, 0);
      end else begin
        sat_mode = $urandom % 2;
        run_seq(src, lp, 0, 0);
      end
      clear_cause();
      repeat (20) @(negedge clk);
      sat_mode = 1'b0;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule